// File: doc/BRIEF.md
# Binary-Search Oscillator Tuning Controller

This controller chooses the 5-bit tuning word of a digitally controlled oscillator so that the oscillator's divided feedback clock runs at a programmed multiple of the reference clock. It works in two phases. During acquisition it measures frequency by counting feedback events over a fixed window of reference cycles. It then moves the tuning word up or down by a step that halves after every window. During tracking it nudges the word by one unit per reference cycle, following a single early/late bit from a bang-bang phase detector.

The whole block runs on the reference clock. Feedback activity arrives as a toggle line: every change of level is one feedback event. A two-flop synchronizer brings the line into the reference domain and an edge detector follows it. The initial step is loaded from an input, so the search may start with a half-scale jump or with a narrower one. A one-cycle start pulse restarts acquisition at any time.

Top module: `dco_acq`

## Requirements
- R1: After reset the tuning word is 16 (mid-scale) and the lock flag is 0. The word stays at 16 until a start pulse arrives, whatever the feedback line and the early/late bit do.
- R2: On the clock after a start pulse, the tuning word is 16, the lock flag is 0, the step register holds the initial-step input and a new measuring window begins. A start pulse overrides a window decision or a tracking update that falls in the same cycle.
- R3: Every level change of the feedback toggle line is counted as one event. A change driven before clock edge m is counted at edge m+2. It belongs to the window that contains edge m+2, so an event that reaches the counter at the final edge of a window still counts toward that window.
- R4: A measuring window lasts WIN_CYC reference cycles. During acquisition the tuning word changes only at the last edge of a window.
- R5: At the end of a window the event count is compared with the threshold (target × WIN_CYC) >> TGT_FRAC. If the count is below the threshold, the word rises by the current step. If it is above, the word falls by the step. If the two are equal, the word is unchanged.
- R6: A search move that would leave the range 0..31 saturates at 0 or 31.
- R7: After each window the step halves (a right shift). The window that uses a step of 1 or less ends acquisition. On that same edge the lock flag rises and tracking begins.
- R8: While locked, each reference cycle moves the word once: +1 when the early/late bit is 1 (late) and −1 when it is 0 (early). The word holds at 31 and at 0.
- R9: While not locked, the early/late bit has no effect on the tuning word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that restarts acquisition |
| fb_toggle | input | 1 | Feedback line; each level change is one event (asynchronous) |
| target | input | TGT_W | Target rate, events per reference cycle with TGT_FRAC fraction bits |
| init_step | input | CODE_W | Initial search step |
| pd_late | input | 1 | Phase-detector bit: 1 = late, 0 = early |
| tune_code | output | CODE_W | Oscillator tuning word |
| locked | output | 1 | High while tracking |

## Verification
A start pulse and the end of a measuring window can fall in the same cycle, and so can a start pulse and a tracking update. The bench raises start in the final cycle of a window whose count would move the word, and again while the controller is tracking. At the next sampling point it expects the word to be 16 with the lock flag clear, and then runs a complete search from that restart. A second coincidence is a feedback event that reaches the counter on the last edge of a window. The bench places event bursts so that they end exactly there, and every window decision must still match an arithmetic model.

// File: rtl/dco_acq_pkg.sv
package dco_acq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2
    } acq_state_e;
endpackage

// File: rtl/dco_fb_sync.sv
// Brings the asynchronous feedback toggle line into the reference domain
// and flags each level change as a one-cycle event.
module dco_fb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_toggle,
    output logic event_o
);
    // chain[STAGES-1] is the last synchronizer flop, chain[STAGES] its delayed copy
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], fb_toggle};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign event_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/dco_win_count.sv
// Counts feedback events over a fixed window of reference cycles.
module dco_win_count #(
    parameter int WIN_CYC = 16,
    parameter int CNT_W   = $clog2(WIN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             event_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int CYC_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(WIN_CYC - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    assign done_o  = run && (win_q.cyc == CYC_LAST);
    // the event seen in the last cycle still belongs to this window
    assign count_o = win_q.cnt + CNT_W'(event_i);

    always_comb begin
        win_d = win_q;
        if (clear) begin
            win_d = '0;
        end else if (run) begin
            if (done_o) begin
                win_d = '0;
            end else begin
                win_d.cyc = win_q.cyc + 1'b1;
                win_d.cnt = win_q.cnt + CNT_W'(event_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/dco_acq.sv
// Oscillator tuning controller: counter-based binary search, then
// single-bit bang-bang tracking.
module dco_acq
    import dco_acq_pkg::*;
#(
    parameter int CODE_W   = 5,
    parameter int WIN_CYC  = 16,
    parameter int TGT_W    = 8,
    parameter int TGT_FRAC = 4,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fb_toggle,
    input  logic [TGT_W-1:0]  target,
    input  logic [CODE_W-1:0] init_step,
    input  logic              pd_late,
    output logic [CODE_W-1:0] tune_code,
    output logic              locked
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam int THR_W = TGT_W + $clog2(WIN_CYC + 1) + 1;
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    typedef struct packed {
        acq_state_e        st;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] step;
        logic              lock;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             fb_event;
    logic             win_run, win_clear, win_done;
    logic [CNT_W-1:0] win_count;
    logic [THR_W-1:0] thr;
    logic [CODE_W:0]  up_sum;
    logic [CODE_W-1:0] step_q;

    dco_fb_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_toggle (fb_toggle),
        .event_o   (fb_event)
    );

    assign win_run   = (ctrl_q.st == ST_SEARCH) && !start;
    assign win_clear = start || (ctrl_q.st != ST_SEARCH);

    dco_win_count #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (win_run),
        .clear   (win_clear),
        .event_i (fb_event),
        .done_o  (win_done),
        .count_o (win_count)
    );

    assign thr    = (THR_W'(target) * THR_W'(WIN_CYC)) >> TGT_FRAC;
    assign up_sum = {1'b0, ctrl_q.code} + {1'b0, ctrl_q.step};
    assign step_q = ctrl_q.step;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ST_SEARCH: begin
                if (win_done) begin
                    if (THR_W'(win_count) < thr) begin
                        ctrl_d.code = up_sum[CODE_W] ? CODE_MAX : up_sum[CODE_W-1:0];
                    end else if (THR_W'(win_count) > thr) begin
                        ctrl_d.code = (ctrl_q.step > ctrl_q.code) ? CODE_MIN
                                                                  : ctrl_q.code - ctrl_q.step;
                    end
                    if (ctrl_q.step <= CODE_W'(1)) begin
                        ctrl_d.st   = ST_TRACK;
                        ctrl_d.lock = 1'b1;
                    end else begin
                        ctrl_d.step = ctrl_q.step >> 1;
                    end
                end
            end
            ST_TRACK: begin
                if (pd_late) begin
                    if (ctrl_q.code != CODE_MAX) ctrl_d.code = ctrl_q.code + 1'b1;
                end else begin
                    if (ctrl_q.code != CODE_MIN) ctrl_d.code = ctrl_q.code - 1'b1;
                end
            end
            default: ;
        endcase
        if (start) begin
            ctrl_d.st   = ST_SEARCH;
            ctrl_d.code = CODE_MID;
            ctrl_d.step = init_step;
            ctrl_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.code <= CODE_MID;
            ctrl_q.step <= '0;
            ctrl_q.lock <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign tune_code = ctrl_q.code;
    assign locked    = ctrl_q.lock;
endmodule

// File: rtl/dco_acq_chk.sv
module dco_acq_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              pd_late,
    input logic [CODE_W-1:0] tune_code,
    input logic              locked,
    input logic              win_done,
    input logic [CODE_W-1:0] step_q
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] TOP = '1;

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (tune_code == MID) && !locked);

    assert_hold_between_windows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !start && !win_done) |=> $stable(tune_code));

    assert_lock_after_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !start && win_done && step_q <= CODE_W'(1)) |=> locked);

    assert_track_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start && pd_late && tune_code != TOP) |=> tune_code == $past(tune_code) + 1'b1);

    assert_track_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start && !pd_late && tune_code != '0) |=> tune_code == $past(tune_code) - 1'b1);

    assert_track_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start && ((pd_late && tune_code == TOP) || (!pd_late && tune_code == '0)))
        |=> $stable(tune_code));
endmodule

bind dco_acq dco_acq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pd_late   (pd_late),
    .tune_code (tune_code),
    .locked    (locked),
    .win_done  (win_done),
    .step_q    (step_q)
);

// File: tb/dco_acq_test.sv
module dco_acq_test;
    localparam int WIN = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       fb_toggle = 1'b0;
    logic [6:0] target = '0;
    logic [4:0] init_step = '0;
    logic       pd_late = 1'b0;
    logic [4:0] tune_code;
    logic       locked;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    dco_acq #(.CODE_W(5), .WIN_CYC(WIN), .TGT_W(7), .TGT_FRAC(6)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .fb_toggle(fb_toggle),
        .target(target), .init_step(init_step), .pd_late(pd_late),
        .tune_code(tune_code), .locked(locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pulse start for one cycle; returns at the negedge that opens window cycle 0.
    task automatic do_start(input int t, input int s);
        target    = 7'(t);
        init_step = 5'(s);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(tune_code == 5'd16, "R2 code after start", tune_code, 16);
        chk(locked == 1'b0, "R2 lock after start", locked, 0);
    endtask

    // Runs search windows from code 16; the oscillator yields code+16 events per window.
    task automatic search_body(input int t, input int s, output int mcode);
        int  mstep;
        bit  mlock;
        int  wnum;
        mcode = 16; mstep = s; mlock = 0; wnum = 0;
        while (!mlock) begin
            int k;
            int first;
            k = mcode + 16;
            first = (wnum % 2 == 0) ? 8 : 62 - k;   // odd windows end at the boundary (R3)
            for (int j = 0; j < WIN; j++) begin
                pd_late = j[0];                      // R9: toggling bit during search
                if (j >= first && j < first + k) fb_toggle = ~fb_toggle;
                if (j == 32)
                    chk(tune_code == 5'(mcode), "R4 R9 code stable mid-window", tune_code, mcode);
                @(negedge clk);
            end
            if (mcode + 16 < t)      mcode = (mcode + mstep > 31) ? 31 : mcode + mstep;
            else if (mcode + 16 > t) mcode = (mstep > mcode) ? 0 : mcode - mstep;
            if (mstep <= 1) mlock = 1; else mstep = mstep >> 1;
            chk(tune_code == 5'(mcode), "R3 R5 R6 R7 code after window", tune_code, mcode);
            chk(locked == mlock, "R7 lock after window", locked, int'(mlock));
            wnum++;
        end
    endtask

    task automatic track(input int start_code, input int cycles, input int mode);
        int m;
        m = start_code;
        for (int i = 0; i < cycles; i++) begin
            bit late;
            late = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : i[1];
            pd_late = late;
            @(negedge clk);
            if (late) m = (m == 31) ? 31 : m + 1;
            else      m = (m == 0) ? 0 : m - 1;
            chk(tune_code == 5'(m), "R8 tracking step", tune_code, m);
            chk(locked == 1'b1, "R8 lock held", locked, 1);
        end
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk(tune_code == 5'd16, "R1 reset code", tune_code, 16);
        chk(locked == 1'b0, "R1 reset lock", locked, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            pd_late = i[0];
            fb_toggle = ~fb_toggle;
            @(negedge clk);
        end
        chk(tune_code == 5'd16, "R1 idle hold", tune_code, 16);
        chk(locked == 1'b0, "R1 idle lock", locked, 0);

        // sweep all targets for three initial steps
        for (int si = 0; si < 3; si++) begin
            int s;
            s = (si == 0) ? 16 : (si == 1) ? 5 : 1;
            for (int t = 0; t < 64; t++) begin
                do_start(t, s);
                search_body(t, s, c);
            end
        end

        // tracking: climb to top, descend to bottom, alternate
        do_start(40, 16);
        search_body(40, 16, c);
        track(c, 40, 1);
        track(31, 40, 0);
        track(0, 16, 2);

        // start while tracking overrides the update (R2)
        pd_late = 1'b1;
        do_start(20, 8);
        search_body(20, 8, c);

        // start in the last cycle of a deciding window (R2 priority)
        do_start(63, 16);
        for (int j = 0; j < WIN - 1; j++) @(negedge clk);
        do_start(10, 16);
        search_body(10, 16, c);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule